// File: doc/BRIEF.md
# Watchdog Reset Control Router

This block sits between a set of watchdog timers and the chip's reset distribution. It watches one request line from each watchdog. When a watchdog fires, the block looks up that watchdog's programmable reset-control word. If the word selects the CPU cores, the block drives a CPU reset pulse of fixed length. Any other target choice is not acted on. Instead, the block records a sticky "unsupported request" flag for that watchdog, which software can read and then clear.

Software reaches the three control words and the flag register over a simple 32-bit register bus. The bus has a byte address and byte enables. Only whole aligned words are honoured. Anything else, and any address outside the four words, reads as zero and leaves state untouched. Read data is registered and appears on the cycle after the request.

Top module: `wdog_rst_router`

## Requirements
- R1: Each of the three request inputs `wd_req_i[i]` is acted on only at a rising edge, where it is low in one cycle and high in the next. A level held high gives one event, and a level already high when reset is released counts as a rising edge.
- R2: The control words for watchdogs 0, 1 and 2 sit at byte addresses 0x0, 0x4 and 0x8. Each stores all 32 bits written to it and reads back what was written. All three hold 0xFFFFFFFF after reset. The flag register is at 0xC and holds 0 after reset.
- R3: A rising edge on input i whose control word has bit 0 set raises `cpu_rst_o` from the cycle after that clock edge. The output stays high for exactly PULSE_LEN cycles (default 4).
- R4: Rising edges on several inputs in the same cycle that select the CPU produce one pulse of PULSE_LEN cycles.
- R5: A CPU-selecting edge that arrives while a pulse is active restarts the count. The pulse then ends PULSE_LEN cycles after the last such edge.
- R6: A rising edge on input i whose control word has bit 0 clear produces no pulse and sets bit i of the flag register (0xC). The bit stays set until software clears it.
- R7: Writing the flag register clears each bit i for which write-data bit i is 1, and leaves bits written with 0 unchanged. If a set and a clear of the same bit happen in one cycle, the bit ends up set. Bits 31..3 read as 0.
- R8: An access acts only when all four byte enables are 1 and address bits [1:0] are 0. Any other access, and any address at or above 0x10, reads as 0 and its write is ignored.
- R9: Read data appears on `bus_rdata_o` in the cycle after the read request. `bus_rdata_o` is 0 in any cycle that follows no read.
- R10: An edge is judged against the control word held before that clock edge. A write landing on the same edge affects only later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wd_req_i | input | NUM_WD (3) | Reset request from each watchdog, synchronous to clk |
| bus_valid_i | input | 1 | Register access request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (12) | Byte address |
| bus_be_i | input | 4 | Byte enables; all four must be set for the access to act |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| cpu_rst_o | output | 1 | CPU reset pulse, active high |

## Verification
Every result of this block appears exactly one clock edge after its cause. The CPU pulse is high at the first falling edge after the clock edge that saw the watchdog edge. A flag set by that same clock edge is visible to a read issued in the next cycle. Read data sits on the bus one edge after the request. The bench therefore drives all inputs at a falling edge and samples at the following falling edge. It counts pulse width as the number of falling edges at which the pulse is high inside a fixed window after the trigger, so the start cycle and the length are both pinned down. The same-edge cases (a write landing with an edge, a clear landing with a set) are driven in one falling-edge slot so that both act on the same clock edge.

// File: rtl/wdr_pkg.sv
// Shared types for the watchdog reset control router.
// Assumes a 32-bit register bus with four byte enables.
package wdr_pkg;

    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef logic [DATA_W-1:0] word_t;

    // Result of decoding one bus access.
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_CTRL   = 2'd1,
        ACC_STATUS = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/wdr_edge_detect.sv
// Rising-edge finder for the watchdog request lines.
// Assumes the inputs are already synchronous to clk. A line high at reset
// release is seen as a rising edge, because the history resets to zero.
module wdr_edge_detect #(
    parameter int NUM_WD = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_WD-1:0] req_i,
    output logic [NUM_WD-1:0] rise_o
);

    logic [NUM_WD-1:0] req_q;

    // Keep last cycle's request levels.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_i;
    end

    assign rise_o = req_i & ~req_q;

    for (genvar i = 0; i < NUM_WD; i++) begin : g_chk
        // R1
        single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[i] |=> !rise_o[i]);
    end

endmodule

// File: rtl/wdr_pulse_gen.sv
// Fixed-length pulse generator for the CPU reset output.
// A trigger loads the down-counter with PULSE_LEN, so a trigger during
// an active pulse restarts it. Output is high while the counter is nonzero.
module wdr_pulse_gen #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger_i,
    output logic pulse_o
);

    localparam int CNT_W = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_LEN);

    logic [CNT_W-1:0] cnt;

    // Load on trigger, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (trigger_i)   cnt <= LOAD_VAL;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign pulse_o = (cnt != '0);

    // R3
    pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LOAD_VAL);

    // R5
    pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && cnt > 1) |=> pulse_o);

endmodule

// File: rtl/wdr_regfile.sv
// Register file of the router: one 32-bit control word per watchdog at
// consecutive word addresses, then a sticky flag register (write 1 to clear).
// Assumes a single-cycle bus. Only full aligned words act. Read data is
// registered and is zero after any cycle without a read.
module wdr_regfile
    import wdr_pkg::*;
#(
    parameter int NUM_WD = 3,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BE_W-1:0]   bus_be_i,
    input  word_t             bus_wdata_i,
    output word_t             bus_rdata_o,
    input  logic [NUM_WD-1:0] flag_set_i,
    output logic [NUM_WD-1:0] cpu_sel_o,
    output logic [NUM_WD-1:0] flags_o
);

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] STATUS_IDX = IDX_W'(NUM_WD);

    word_t             ctrl_q [NUM_WD];
    logic [NUM_WD-1:0] flags_q;
    logic [IDX_W-1:0]  word_idx;
    logic              full_word;
    acc_kind_e         kind;
    logic              wr_en;
    logic              rd_en;
    logic [NUM_WD-1:0] flag_clr;
    word_t             rd_val;

    assign word_idx  = bus_addr_i[ADDR_W-1:2];
    assign full_word = (bus_be_i == '1) && (bus_addr_i[1:0] == 2'b00);
    assign wr_en     = bus_valid_i && bus_write_i;
    assign rd_en     = bus_valid_i && !bus_write_i;

    // Classify the access into control, flag or nothing.
    always_comb begin
        if (!full_word)                 kind = ACC_NONE;
        else if (word_idx < STATUS_IDX) kind = ACC_CTRL;
        else if (word_idx == STATUS_IDX) kind = ACC_STATUS;
        else                            kind = ACC_NONE;
    end

    for (genvar g = 0; g < NUM_WD; g++) begin : g_ctrl
        // Hold one watchdog's control word, all ones at reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctrl_q[g] <= '1;
            else if (wr_en && kind == ACC_CTRL && word_idx == IDX_W'(g))
                ctrl_q[g] <= bus_wdata_i;
        end
        assign cpu_sel_o[g] = ctrl_q[g][0];
    end

    assign flag_clr = (wr_en && kind == ACC_STATUS) ? bus_wdata_i[NUM_WD-1:0] : '0;

    // Sticky flags: a set beats a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flag_clr) | flag_set_i;
    end

    assign flags_o = flags_q;

    // Pick the read value for the decoded word.
    always_comb begin
        rd_val = '0;
        if (kind == ACC_CTRL) begin
            for (int g = 0; g < NUM_WD; g++) begin
                if (word_idx == IDX_W'(g)) rd_val = ctrl_q[g];
            end
        end else if (kind == ACC_STATUS) begin
            rd_val = DATA_W'(flags_q);
        end
    end

    // Register read data; zero when no read was requested.
    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata_o <= '0;
        else if (rd_en) bus_rdata_o <= rd_val;
        else            bus_rdata_o <= '0;
    end

    // R8
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !full_word) |=> (bus_rdata_o == '0));

    // R9
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (bus_rdata_o == '0));

    for (genvar g = 0; g < NUM_WD; g++) begin : g_flag_chk
        // R7
        flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_clr[g] && !flag_set_i[g]) |=> !flags_q[g]);
    end

endmodule

// File: rtl/wdog_rst_router.sv
// Watchdog reset control router.
// Turns watchdog rising edges into a CPU reset pulse when the watchdog's
// control word selects the CPU (bit 0). Otherwise it flags the request as
// unsupported. Assumes synchronous request inputs and a single-cycle bus.
module wdog_rst_router
    import wdr_pkg::*;
#(
    parameter int NUM_WD    = 3,
    parameter int PULSE_LEN = 4,
    parameter int ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_WD-1:0] wd_req_i,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [3:0]        bus_be_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              cpu_rst_o
);

    logic [NUM_WD-1:0] rise;
    logic [NUM_WD-1:0] cpu_sel;
    logic [NUM_WD-1:0] flags;
    logic [NUM_WD-1:0] unsup_set;
    logic              fire_cpu;

    wdr_edge_detect #(.NUM_WD(NUM_WD)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (wd_req_i),
        .rise_o (rise)
    );

    wdr_regfile #(.NUM_WD(NUM_WD), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid_i (bus_valid_i),
        .bus_write_i (bus_write_i),
        .bus_addr_i  (bus_addr_i),
        .bus_be_i    (bus_be_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .flag_set_i  (unsup_set),
        .cpu_sel_o   (cpu_sel),
        .flags_o     (flags)
    );

    // Route each edge: CPU-selecting edges merge into one trigger.
    assign fire_cpu  = |(rise & cpu_sel);
    assign unsup_set = rise & ~cpu_sel;

    wdr_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .trigger_i (fire_cpu),
        .pulse_o   (cpu_rst_o)
    );

    // R3
    cpu_fire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_cpu |=> cpu_rst_o);

    // R3
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_o) |-> $past(fire_cpu));

    for (genvar i = 0; i < NUM_WD; i++) begin : g_route_chk
        // R6
        unsup_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            unsup_set[i] |=> flags[i]);
    end

endmodule

// File: tb/wdog_rst_router_tb.sv
module wdog_rst_router_tb;

    localparam int NUM_WD    = 3;
    localparam int PULSE_LEN = 4;
    localparam int ADDR_W    = 12;
    localparam int NVEC      = 7;

    // vector: {ctrl bit0 per watchdog[2:0], request pattern[2:0], pulse len[3:0], flags[2:0]}
    localparam logic [12:0] VECS [NVEC] = '{
        {3'b111, 3'b001, 4'd4, 3'b000},
        {3'b111, 3'b110, 4'd4, 3'b000},
        {3'b000, 3'b010, 4'd0, 3'b010},
        {3'b101, 3'b111, 4'd4, 3'b010},
        {3'b010, 3'b101, 4'd0, 3'b101},
        {3'b011, 3'b100, 4'd0, 3'b100},
        {3'b100, 3'b100, 4'd4, 3'b000}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_WD-1:0] wd_req = '0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [3:0]        bus_be = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              cpu_rst;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    wdog_rst_router #(.NUM_WD(NUM_WD), .PULSE_LEN(PULSE_LEN), .ADDR_W(ADDR_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wd_req_i    (wd_req),
        .bus_valid_i (bus_valid),
        .bus_write_i (bus_write),
        .bus_addr_i  (bus_addr),
        .bus_be_i    (bus_be),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .cpu_rst_o   (cpu_rst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] be);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [3:0] be, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_be = be;
        @(negedge clk);
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    // Count falling edges with the pulse high in a window after the drive.
    task automatic count_pulse(output int n, output logic first_hi);
        n = 0;
        first_hi = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (k == 0) first_hi = cpu_rst;
            if (cpu_rst) n++;
        end
    endtask

    task automatic quiet();
        wd_req = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        int          n;
        logic        hi;

        repeat (3) @(negedge clk);
        check("R3 reset cpu_rst", 32'(cpu_rst), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset values
        rd(12'h000, 4'hF, d); check("R2 reset ctrl0", d, 32'hFFFF_FFFF);
        rd(12'h004, 4'hF, d); check("R2 reset ctrl1", d, 32'hFFFF_FFFF);
        rd(12'h008, 4'hF, d); check("R2 reset ctrl2", d, 32'hFFFF_FFFF);
        rd(12'h00C, 4'hF, d); check("R2 reset flags", d, 32'h0);
        @(negedge clk);
        check("R9 idle rdata", bus_rdata, 32'h0);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            for (int w = 0; w < NUM_WD; w++)
                wr(12'(w * 4), 32'hA5A5_A5A4 | 32'(VECS[v][12 - (2 - w)]), 4'hF);
            wr(12'h00C, 32'h7, 4'hF);
            quiet();
            wd_req = VECS[v][9:7];
            count_pulse(n, hi);
            check($sformatf("R3/R4/R6 vec%0d pulse", v), 32'(n), 32'(VECS[v][6:3]));
            rd(12'h00C, 4'hF, d);
            check($sformatf("R6 vec%0d flags", v), d, 32'(VECS[v][2:0]));
            quiet();
        end

        // R2 full-width storage
        wr(12'h008, 32'h1234_5679, 4'hF);
        rd(12'h008, 4'hF, d); check("R2 ctrl2 readback", d, 32'h1234_5679);
        wr(12'h000, 32'hFFFF_FFFF, 4'hF);
        wr(12'h004, 32'hFFFF_FFFF, 4'hF);
        wr(12'h008, 32'hFFFF_FFFF, 4'hF);
        wr(12'h00C, 32'h7, 4'hF);

        // R3 start cycle and R1 held level gives one pulse
        wd_req = 3'b001;
        count_pulse(n, hi);
        check("R3 pulse starts next cycle", 32'(hi), 32'h1);
        check("R1 held level single pulse", 32'(n), 32'(PULSE_LEN));
        count_pulse(n, hi);
        check("R1 no pulse while held", 32'(n), 32'h0);
        quiet();

        // R5 retrigger during pulse
        wd_req = 3'b001;
        n = 0;
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            if (cpu_rst) n++;
            if (k == 1) wd_req = 3'b011;
        end
        check("R5 retrigger extends", 32'(n), 32'(PULSE_LEN + 2));
        quiet();

        // R8 partial byte enables, misaligned, out of range
        wr(12'h000, 32'h0, 4'h3);
        rd(12'h000, 4'hF, d); check("R8 partial be write ignored", d, 32'hFFFF_FFFF);
        rd(12'h000, 4'h7, d); check("R8 partial be read zero", d, 32'h0);
        wr(12'h005, 32'h0, 4'hF);
        rd(12'h004, 4'hF, d); check("R8 misaligned write ignored", d, 32'hFFFF_FFFF);
        rd(12'h005, 4'hF, d); check("R8 misaligned read zero", d, 32'h0);
        wr(12'h010, 32'hDEAD_BEEF, 4'hF);
        rd(12'h010, 4'hF, d); check("R8 out of range read", d, 32'h0);
        rd(12'hFFC, 4'hF, d); check("R8 top address read", d, 32'h0);

        // R7 write-one-to-clear
        wr(12'h000, 32'h0, 4'hF);
        wr(12'h004, 32'h0, 4'hF);
        wr(12'h008, 32'h0, 4'hF);
        wd_req = 3'b111;
        @(negedge clk);
        quiet();
        rd(12'h00C, 4'hF, d); check("R7 all flags set", d, 32'h7);
        wr(12'h00C, 32'hFFFF_FFF2 & 32'h0000_0002, 4'hF);
        rd(12'h00C, 4'hF, d); check("R7 clear bit1 only", d, 32'h5);
        wr(12'h00C, 32'h0, 4'hF);
        rd(12'h00C, 4'hF, d); check("R7 write zero keeps", d, 32'h5);

        // R7 set beats clear on the same edge
        wd_req = 3'b001;
        wr(12'h00C, 32'h1, 4'hF);
        rd(12'h00C, 4'hF, d); check("R7 set wins over clear", d, 32'h5);
        quiet();
        wr(12'h00C, 32'h7, 4'hF);

        // R10 write on the same edge as a request uses the old word
        wr(12'h000, 32'h1, 4'hF);
        wd_req = 3'b001;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h000; bus_wdata = 32'h0; bus_be = 4'hF;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        check("R10 old word selects cpu", 32'(cpu_rst), 32'h1);
        repeat (6) @(negedge clk);
        rd(12'h00C, 4'hF, d); check("R10 no flag from old word", d, 32'h0);
        quiet();
        wd_req = 3'b001;
        count_pulse(n, hi);
        check("R10 new word no pulse", 32'(n), 32'h0);
        rd(12'h00C, 4'hF, d); check("R10 new word flags", d, 32'h1);

        summary();
        $finish;
    end

endmodule